// File: doc/BRIEF.md
# Four-Port Registered Bus Exchanger

This block moves words between four equal-width ports, called 1A, 2A, 1B and 2B. Each port has its own input bus, output bus and output-enable bit, which together take the place of a bidirectional pad. A stored routing state chooses which ports act as sources and which act as destinations. The routing can be one-way, which uses one pair of ports, or two-way, which uses two disjoint pairs. Every destination port drives its output from its own register. That register is loaded from the port's assigned source on the clock edge.

Operation has two phases, chosen by a single control input. While `xfer_en` is low, each clock edge stores the 5-bit `route_code` as the new routing state. While it is high, the routing state is frozen and each active destination register captures its source. An asynchronous `preset` clears the routing state and so turns every output off without waiting for a clock. The block turns outputs on again only on a route-loading edge that arrives after the preset has been released.

Top module: `quad_bus_exchanger`

## Requirements
- R1: On a clock edge with `rst_n` low, the routing state is cleared to "all off" and all four data registers are cleared to zero. Afterwards `port_oe` is 0, and a port enabled later without a capture shows 0.
- R2: On an edge with `preset` low and `xfer_en` low, `route_code` becomes the routing state, and `port_oe` reflects it after that edge. No data register loads on such an edge.
- R3: On an edge with `xfer_en` high, the routing state does not change, whatever `route_code` holds.
- R4: On an edge with `xfer_en` high, each enabled destination register loads the value its source port presents on `port_in` at that edge, and shows it on `port_out` after the edge.
- R5: `route_code` is read with bit 4 as the first digit written. Code 0 and the reserved codes 1 to 7 enable no output and load no register.
- R6: Codes with first digits 01 route between 1A and 2A and/or between 1B and 2B. 8: 1A←2A, 2B←1B. 9: 1A←2A. 10: 1B←2B. 11: 1A←2A, 1B←2B. 12: 2A←1A, 2B←1B. 13: 2A←1A. 14: 2B←1B. 15: 2A←1A, 1B←2B.
- R7: Codes with first digits 10 route between 1A and 1B and/or between 2A and 2B. 16: 1B←1A, 2A←2B. 17: 1B←1A. 18: 2B←2A. 19: 1B←1A, 2B←2A. 20: 1A←1B, 2B←2A. 21: 1A←1B. 22: 2A←2B. 23: 1A←1B, 2A←2B.
- R8: Codes with first digits 11 route between 1A and 2B and/or between 2A and 1B. 24: 1A←2B, 1B←2A. 25: 2A←1B. 26: 1A←2B. 27: 1A←2B, 2A←1B. 28: 2B←1A, 2A←1B. 29: 2B←1A. 30: 1B←2A. 31: 2B←1A, 1B←2A.
- R9: Ports are indexed 1A=0, 2A=1, 1B=2, 2B=3 in `port_oe` and in the `DATA_W` slices of `port_in` and `port_out`. Only destinations assert `port_oe`. A port whose enable is low outputs zero, and no port is ever both a source and enabled.
- R10: While `preset` is high, `port_oe` is 0 at once, without a clock edge. Edges during preset change neither the routing state nor any register.
- R11: After `preset` falls, edges with `xfer_en` high keep all outputs off. The first edge with `xfer_en` low loads the new routing.
- R12: A data register keeps its value over any edge that does not capture into it, including route changes. A port enabled again shows the last value captured into it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| preset | input | 1 | Asynchronous active-high output kill |
| xfer_en | input | 1 | 0: load route code; 1: hold route, capture data |
| route_code | input | 5 | Routing selection, bit 4 is the first digit |
| port_in | input | 4*DATA_W | Input words of 1A, 2A, 1B, 2B (lowest slice 1A) |
| port_out | output | 4*DATA_W | Registered output words, zero when not enabled |
| port_oe | output | 4 | Per-port output enable |

## Verification
The preset is asynchronous, while route loading and data capture are clocked, so a preset can coincide with a clock edge that would otherwise load a route or capture data. The bench raises `preset` between edges and checks the enables in the same cycle, before any clock. It then applies a route-load edge and a capture edge while preset is held, and checks that the outputs stay off and that the register seen later keeps its earlier word. Preset release is tested the same way: an edge with `xfer_en` high must leave everything off, and the following load edge must restore exactly the new routing with the register contents unchanged.

// File: rtl/xchg_pkg.sv
// Shared definitions for the four-port exchanger.
// Port index order is fixed: 1A=0, 2A=1, 1B=2, 2B=3.
// The routing decode is held here as a function so that every user sees one table.
package xchg_pkg;

    localparam int NPORT  = 4;
    localparam int CODE_W = 5;
    localparam int IDX_W  = $clog2(NPORT);

    typedef logic [IDX_W-1:0] port_idx_t;

    localparam port_idx_t P1A = 2'd0;
    localparam port_idx_t P2A = 2'd1;
    localparam port_idx_t P1B = 2'd2;
    localparam port_idx_t P2B = 2'd3;

    // Decoded routing: which ports are written, which are read, and each writer's source.
    typedef struct packed {
        logic [NPORT-1:0]      dst_en;
        logic [NPORT-1:0]      src_rd;
        port_idx_t [NPORT-1:0] src;
    } route_t;

    // Add one source-to-destination link to a routing.
    function automatic route_t link(input route_t r, input port_idx_t d, input port_idx_t s);
        route_t t;
        t = r;
        t.dst_en[d] = 1'b1;
        t.src_rd[s] = 1'b1;
        t.src[d]    = s;
        return t;
    endfunction

    // Map a route code to its links; off and reserved codes give an empty routing.
    function automatic route_t decode_route(input logic [CODE_W-1:0] code);
        route_t r;
        r = '0;
        case (code)
            5'b01000: r = link(link(r, P1A, P2A), P2B, P1B);
            5'b01001: r = link(r, P1A, P2A);
            5'b01010: r = link(r, P1B, P2B);
            5'b01011: r = link(link(r, P1A, P2A), P1B, P2B);
            5'b01100: r = link(link(r, P2A, P1A), P2B, P1B);
            5'b01101: r = link(r, P2A, P1A);
            5'b01110: r = link(r, P2B, P1B);
            5'b01111: r = link(link(r, P2A, P1A), P1B, P2B);
            5'b10000: r = link(link(r, P1B, P1A), P2A, P2B);
            5'b10001: r = link(r, P1B, P1A);
            5'b10010: r = link(r, P2B, P2A);
            5'b10011: r = link(link(r, P1B, P1A), P2B, P2A);
            5'b10100: r = link(link(r, P1A, P1B), P2B, P2A);
            5'b10101: r = link(r, P1A, P1B);
            5'b10110: r = link(r, P2A, P2B);
            5'b10111: r = link(link(r, P1A, P1B), P2A, P2B);
            5'b11000: r = link(link(r, P1A, P2B), P1B, P2A);
            5'b11001: r = link(r, P2A, P1B);
            5'b11010: r = link(r, P1A, P2B);
            5'b11011: r = link(link(r, P1A, P2B), P2A, P1B);
            5'b11100: r = link(link(r, P2B, P1A), P2A, P1B);
            5'b11101: r = link(r, P2B, P1A);
            5'b11110: r = link(r, P1B, P2A);
            5'b11111: r = link(link(r, P2B, P1A), P1B, P2A);
            default:  r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/xchg_route_reg.sv
// Routing-state register.
// Loads the code on edges with xfer_en low; holds it while xfer_en is high.
// Assumes preset is asynchronous and forces the "all off" code (zero) at once.
module xchg_route_reg
    import xchg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              preset,
    input  logic              xfer_en,
    input  logic [CODE_W-1:0] route_code,
    output logic [CODE_W-1:0] route_q
);

    // Store the routing state: async clear on preset, sync clear on reset, load in route phase.
    always_ff @(posedge clk or posedge preset) begin
        if (preset) begin
            route_q <= '0;
        end else if (!rst_n) begin
            route_q <= '0;
        end else if (!xfer_en) begin
            route_q <= route_code;
        end
    end

    // R2
    route_load_chk: assert property (@(posedge clk) disable iff (!rst_n || preset)
        !xfer_en |=> (route_q == $past(route_code)));

    // R3
    route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || preset)
        xfer_en |=> $stable(route_q));

    // R11
    stay_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_en && route_q == '0) |=> (route_q == '0));

endmodule

// File: rtl/xchg_route_dec.sv
// Combinational routing decoder.
// Turns the stored route code into destination enables, a read mask and per-destination sources.
module xchg_route_dec
    import xchg_pkg::*;
(
    input  logic [CODE_W-1:0] route_q,
    output route_t            route
);

    // Look the stored code up in the shared table.
    always_comb begin
        route = decode_route(route_q);
    end

endmodule

// File: rtl/xchg_lane.sv
// One destination lane: a source mux, the data register and the output gate.
// Assumes cap_en is already limited to capture edges for which this lane is a destination.
module xchg_lane
    import xchg_pkg::*;
#(
    parameter int DATA_W = 9,
    localparam int BUS_W = NPORT * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              dst_en,
    input  port_idx_t         sel,
    input  logic [BUS_W-1:0]  bus_in,
    output logic [DATA_W-1:0] lane_out,
    output logic              lane_oe
);

    logic [DATA_W-1:0] src_word;
    logic [DATA_W-1:0] lane_q;

    // Pick the source word for this destination.
    always_comb begin
        src_word = bus_in[int'(sel)*DATA_W +: DATA_W];
    end

    // Capture the source on capture edges; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else if (cap_en) begin
            lane_q <= src_word;
        end
    end

    // Drive the register only while this port is a destination.
    always_comb begin
        lane_oe  = dst_en;
        lane_out = dst_en ? lane_q : '0;
    end

    // R4
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (lane_q == $past(src_word)));

    // R12
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(lane_q));

endmodule

// File: rtl/quad_bus_exchanger.sv
// Four-port registered bus exchanger (top).
// Wires the routing register, the decoder and one lane per port.
// Assumes port order 1A, 2A, 1B, 2B from the lowest slice up, and a preset that is asynchronous.
module quad_bus_exchanger
    import xchg_pkg::*;
#(
    parameter int DATA_W = 9,
    localparam int BUS_W = NPORT * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              preset,
    input  logic              xfer_en,
    input  logic [CODE_W-1:0] route_code,
    input  logic [BUS_W-1:0]  port_in,
    output logic [BUS_W-1:0]  port_out,
    output logic [NPORT-1:0]  port_oe
);

    logic [CODE_W-1:0] route_q;
    route_t            route;

    xchg_route_reg u_route_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .preset     (preset),
        .xfer_en    (xfer_en),
        .route_code (route_code),
        .route_q    (route_q)
    );

    xchg_route_dec u_route_dec (
        .route_q (route_q),
        .route   (route)
    );

    for (genvar i = 0; i < NPORT; i++) begin : g_lane
        xchg_lane #(.DATA_W(DATA_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .cap_en   (xfer_en & route.dst_en[i]),
            .dst_en   (route.dst_en[i]),
            .sel      (route.src[i]),
            .bus_in   (port_in),
            .lane_out (port_out[i*DATA_W +: DATA_W]),
            .lane_oe  (port_oe[i])
        );
    end

    // R1
    reset_off_chk: assert property (@(posedge clk)
        !rst_n |=> (port_oe == '0));

    // R10
    preset_off_chk: assert property (@(posedge clk)
        preset |-> (port_oe == '0));

    // R5
    reserved_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (route_q[CODE_W-1 -: 2] == 2'b00) |-> (port_oe == '0));

    // R9
    no_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_oe & route.src_rd) == '0);

endmodule

// File: tb/quad_bus_exchanger_tb.sv
module quad_bus_exchanger_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W = 9;
    localparam int NP = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            preset = 1'b0;
    logic            xfer_en = 1'b1;
    logic [4:0]      route_code = '0;
    logic [NP*W-1:0] port_in = '0;
    logic [NP*W-1:0] port_out;
    logic [NP-1:0]   port_oe;

    int n_chk = 0;
    int n_bad = 0;

    int         m_code = 0;
    logic [W-1:0] m_reg [NP];
    logic [W-1:0] drv [NP];

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_bus_exchanger #(.DATA_W(W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .preset     (preset),
        .xfer_en    (xfer_en),
        .route_code (route_code),
        .port_in    (port_in),
        .port_out   (port_out),
        .port_oe    (port_oe)
    );

    // Routing as one hex digit per destination (1A,2A,1B,2B from the top digit); digit = source index + 1.
    function automatic logic [15:0] rt_word(input int c);
        case (c)
            8:  return 16'h2003;  9:  return 16'h2000; 10: return 16'h0040; 11: return 16'h2040;
            12: return 16'h0103; 13: return 16'h0100; 14: return 16'h0003; 15: return 16'h0140;
            16: return 16'h0410; 17: return 16'h0010; 18: return 16'h0002; 19: return 16'h0012;
            20: return 16'h3002; 21: return 16'h3000; 22: return 16'h0400; 23: return 16'h3400;
            24: return 16'h4020; 25: return 16'h0300; 26: return 16'h4000; 27: return 16'h4300;
            28: return 16'h0301; 29: return 16'h0001; 30: return 16'h0020; 31: return 16'h0021;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic int src_of(input int c, input int d);
        return int'((rt_word(c) >> (4 * (3 - d))) & 16'hf);
    endfunction

    function automatic logic [3:0] mask_of(input int c);
        logic [3:0] m;
        m = '0;
        for (int d = 0; d < NP; d++) m[d] = (src_of(c, d) != 0);
        return m;
    endfunction

    function automatic string grp(input int c);
        if (c < 8)  return "R5";
        if (c < 16) return "R6";
        if (c < 24) return "R7";
        return "R8";
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_in(input int seed);
        for (int p = 0; p < NP; p++) begin
            drv[p] = W'((seed * 37 + p * 59 + 5) & ((1 << W) - 1));
            port_in[p*W +: W] = drv[p];
        end
    endtask

    // Compare enables and every output against the model; enabled ports tagged with req.
    task automatic check_ports(input string oe_req, input string req);
        chk(oe_req, 32'(port_oe), 32'(mask_of(m_code)));
        for (int d = 0; d < NP; d++) begin
            if (src_of(m_code, d) != 0)
                chk(req, 32'(port_out[d*W +: W]), 32'(m_reg[d]));
            else
                chk("R9", 32'(port_out[d*W +: W]), 32'd0);
        end
    endtask

    task automatic do_load(input int c, input int seed);
        route_code = 5'(c);
        xfer_en = 1'b0;
        set_in(seed);
        step();
        m_code = c;
    endtask

    task automatic do_cap(input int seed);
        xfer_en = 1'b1;
        route_code = ~route_code;
        set_in(seed);
        step();
        for (int d = 0; d < NP; d++)
            if (src_of(m_code, d) != 0) m_reg[d] = drv[src_of(m_code, d) - 1];
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int d = 0; d < NP; d++) m_reg[d] = '0;
        set_in(1);
        @(negedge clk);
        step();
        step();
        // R1: reset state
        chk("R1", 32'(port_oe), 32'd0);
        chk("R1", 32'(port_out), 32'd0);
        rst_n = 1'b1;

        // Sweep every code: load (R2/R5..R8), hold across capture (R3), two captures (R4).
        for (int c = 0; c < 32; c++) begin
            do_load(c, c + 100);
            check_ports(grp(c), "R2");
            do_cap(c * 3 + 1);
            chk("R3", 32'(port_oe), 32'(mask_of(c)));
            check_ports(grp(c), "R4");
            do_cap(c * 7 + 2);
            check_ports(grp(c), "R4");
        end

        // R12: route changes keep register contents.
        do_load(0, 500);
        check_ports("R5", "R12");
        do_load(21, 501);
        check_ports("R7", "R12");
        do_load(9, 502);
        check_ports("R6", "R12");
        do_load(31, 503);
        check_ports("R8", "R12");

        // R10: preset kills outputs between edges and blocks load and capture.
        do_load(13, 600);
        do_cap(601);
        check_ports("R6", "R4");
        #2;
        preset = 1'b1;
        #1;
        chk("R10", 32'(port_oe), 32'd0);
        chk("R10", 32'(port_out), 32'd0);
        m_code = 0;
        @(negedge clk);
        xfer_en = 1'b0;
        route_code = 5'd12;
        set_in(602);
        step();
        chk("R10", 32'(port_oe), 32'd0);
        xfer_en = 1'b1;
        set_in(603);
        step();
        chk("R10", 32'(port_oe), 32'd0);
        chk("R10", 32'(port_out), 32'd0);

        // R11: release with xfer_en high stays off; next load edge restores routing.
        preset = 1'b0;
        set_in(604);
        step();
        chk("R11", 32'(port_oe), 32'd0);
        chk("R11", 32'(port_out), 32'd0);
        do_load(13, 605);
        chk("R11", 32'(port_oe), 32'(mask_of(13)));
        chk("R10", 32'(port_out[1*W +: W]), 32'(m_reg[1]));

        // R1: reset mid-run clears route and registers.
        rst_n = 1'b0;
        step();
        m_code = 0;
        for (int d = 0; d < NP; d++) m_reg[d] = '0;
        chk("R1", 32'(port_oe), 32'd0);
        rst_n = 1'b1;
        do_load(11, 700);
        check_ports("R6", "R1");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule